// File: doc/BRIEF.md
# Configurable UART Frame Transceiver

This block is a full-duplex asynchronous serial transceiver. A byte offered on a valid/ready transmit interface is wrapped into a frame. The frame has a low start bit, then the data bits, then an optional parity bit, then one or two high stop bits. The frame is shifted out on `txd`. On the receive side the serial input is synchronised and a start edge is detected. Each bit is sampled at its centre, and the character is delivered together with framing, parity and overrun flags. The bit rate comes from an external `baud_tick` strobe, and sixteen ticks make one bit time.

A 3-bit mode input sets the character length: 7, 8 or 9 bits. Any other mode code shuts the serial function down. The character format has five further controls:
- first-bit order, which applies to 8-bit characters only;
- inversion of the data bits on the line;
- parity on or off;
- odd or even parity;
- the number of stop bits.

Two recovery actions are provided for use after a line error. Dropping `rx_en` and raising it again clears the receiver. Setting the mode to a non-UART code clears the transmitter, and a write of 1 to the transmit-enable strobe `tx_arm` then re-arms it.

Top module: `uart_xcvr`

## Requirements
- R1: `txd` idles high. Each frame sends a low start bit, then the data bits, then the parity bit if enabled, then the stop bits, and every bit lasts exactly 16 `baud_tick` pulses. `txd` changes only on a tick or on the clock edge that accepts a byte.
- R2: With `msb_first`=1 and an 8-bit mode, data bit 7 is sent first and the first received data bit lands in bit 7. In the 7-bit and 9-bit modes, bit 0 always goes first in both directions.
- R3: With `invert`=1, every data bit on the line is the complement of the character bit, in both directions. The start, parity and stop bits are never inverted.
- R4: With `par_en`=1, one parity bit follows the data. It is computed over the uninverted character: `par_odd`=0 makes the count of ones across data and parity even, and `par_odd`=1 makes it odd. With `par_en`=0 no parity bit is sent or expected.
- R5: `two_stop`=0 sends one stop bit and `two_stop`=1 sends two. The receiver checks every stop bit it expects.
- R6: `tx_ready` equals "transmitter armed and no frame in progress". A byte is taken on a cycle with `tx_valid` and `tx_ready` both high, and the start bit appears on `txd` in the next cycle.
- R7: Mode 100 selects 7-bit characters, 101 selects 8-bit and 110 selects 9-bit. Any other code aborts a frame in progress, forces `txd` high, disarms the transmitter and holds the receiver cleared. After reset or disarm, `tx_ready` stays low until a `tx_arm` pulse arrives under a UART mode, and a `tx_arm` pulse while already armed keeps the transmitter armed.
- R8: A start is recognised on a falling edge of the synchronised line. It is accepted only if the line is still low 8 ticks later. A shorter low pulse is discarded, and the receiver then waits for the next falling edge.
- R9: A completed character sets `rx_valid` and presents the character on `rx_data`, with unused upper bits 0. A `rx_read` pulse clears `rx_valid` and all three flags.
- R10: A low level sampled in any expected stop bit sets `rx_frame_err` for that character.
- R11: A received parity bit that disagrees with the parity of the received character sets `rx_par_err`.
- R12: If a character completes while `rx_valid` is high and `rx_read` is low, the held character is kept and `rx_overrun` is set.
- R13: While `rx_en` is low, `rx_valid` and every flag read 0 and any partial frame is dropped. After `rx_en` rises again, reception restarts from the next start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| mode | input | 3 | Character length code; other codes disable |
| msb_first | input | 1 | Send and receive bit 7 first (8-bit mode only) |
| invert | input | 1 | Complement data bits on the line |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| two_stop | input | 1 | 1 = two stop bits |
| tx_arm | input | 1 | Pulse: write 1 to transmit enable |
| rx_en | input | 1 | Receive enable level |
| tx_data | input | 9 | Character to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter can take a character |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_read | input | 1 | Pulse: consume the held character |
| rx_data | output | 9 | Received character |
| rx_valid | output | 1 | A character is held |
| rx_frame_err | output | 1 | Held character had a low stop bit |
| rx_par_err | output | 1 | Held character had a parity mismatch |
| rx_overrun | output | 1 | A character was lost while one was held |

## Verification
Any fault in the transmit shift register, bit counter or tick counter shows up on `txd` or `tx_ready` within one bit time, because both are compared against an independent cycle model on every clock. Receiver state faults are different. A miscounted bit index, a wrong sample point or a skipped stop check stays hidden until the character completes. It then appears as a wrong `rx_data` or a wrong flag at the end of that frame, so every receive case is checked right after its last stop bit. Loopback frames tie the two paths together, so an ordering or inversion fault that is symmetric would still show up in the line-level comparison.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

    localparam int unsigned DATA_MAX = 9;
    localparam int unsigned STOP_MAX = 2;
    localparam int unsigned FRAME_W  = 1 + DATA_MAX + 1 + STOP_MAX;
    localparam int unsigned CNT_W    = $clog2(FRAME_W + 1);

    typedef logic [DATA_MAX-1:0] data_t;

    typedef enum logic [2:0] {
        MODE_OFF = 3'b000,
        MODE_CH7 = 3'b100,
        MODE_CH8 = 3'b101,
        MODE_CH9 = 3'b110
    } mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] nbits;
        logic             msb_first;
        logic             invert;
        logic             par_en;
        logic             par_odd;
        logic             two_stop;
    } line_cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [CNT_W-1:0]   count;
    } frame_t;

    typedef struct packed {
        data_t data;
        logic  frame_err;
        logic  par_err;
    } rx_word_t;

    function automatic logic mode_is_uart(input logic [2:0] m);
        return (m == MODE_CH7) || (m == MODE_CH8) || (m == MODE_CH9);
    endfunction

    function automatic logic [CNT_W-1:0] mode_bits(input logic [2:0] m);
        if (m == MODE_CH7) return CNT_W'(7);
        if (m == MODE_CH9) return CNT_W'(9);
        return CNT_W'(8);
    endfunction

    // zero every bit above the character length
    function automatic data_t mask_data(input data_t d, input logic [CNT_W-1:0] n);
        data_t r;
        for (int i = 0; i < int'(DATA_MAX); i++)
            r[i] = (i < int'(n)) ? d[i] : 1'b0;
        return r;
    endfunction

    // even: xor of data; odd: its complement
    function automatic logic parity_of(input data_t d, input line_cfg_t c);
        logic p;
        p = c.par_odd;
        for (int i = 0; i < int'(DATA_MAX); i++)
            if (i < int'(c.nbits)) p = p ^ d[i];
        return p;
    endfunction

    // bit reversal of the low byte, only for 8-bit characters; self-inverse
    function automatic data_t reorder(input data_t d, input line_cfg_t c);
        data_t r;
        r = d;
        if (c.msb_first && (c.nbits == CNT_W'(8)))
            for (int i = 0; i < 8; i++) r[i] = d[7-i];
        return r;
    endfunction

    function automatic frame_t build_frame(input data_t d, input line_cfg_t c);
        frame_t f;
        data_t  m;
        data_t  o;
        int     pos;
        m      = mask_data(d, c.nbits);
        o      = reorder(m, c);
        f.bits = '1;
        f.bits[0] = 1'b0;
        for (int i = 0; i < int'(DATA_MAX); i++)
            if (i < int'(c.nbits)) f.bits[1+i] = o[i] ^ c.invert;
        pos = 1 + int'(c.nbits);
        if (c.par_en) begin
            f.bits[pos] = parity_of(m, c);
            pos = pos + 1;
        end
        f.count = CNT_W'(pos + 1 + int'(c.two_stop));
        return f;
    endfunction

endpackage

// File: rtl/uart_xcvr_sync.sv
module uart_xcvr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_xcvr_tx.sv
module uart_xcvr_tx
    import uart_xcvr_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  line_cfg_t cfg,
    input  logic      tick,
    input  logic      arm,
    input  data_t     tx_data,
    input  logic      tx_valid,
    output logic      tx_ready,
    output logic      txd
);
    localparam int unsigned TW = $clog2(OSR);
    localparam logic [TW-1:0] T_LAST = TW'(OSR - 1);

    logic               armed;
    logic               busy;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   left;
    logic [TW-1:0]      tcnt;
    frame_t             next_frame;

    always_comb next_frame = build_frame(tx_data, cfg);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            armed <= 1'b0;
            busy  <= 1'b0;
            shreg <= '1;
            left  <= '0;
            tcnt  <= '0;
        end else begin
            if (arm) armed <= 1'b1;
            if (busy) begin
                if (tick) begin
                    if (tcnt == T_LAST) begin
                        tcnt  <= '0;
                        shreg <= {1'b1, shreg[FRAME_W-1:1]};
                        left  <= left - 1'b1;
                        if (left == CNT_W'(1)) busy <= 1'b0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
            end else if (armed && tx_valid) begin
                shreg <= next_frame.bits;
                left  <= next_frame.count;
                tcnt  <= '0;
                busy  <= 1'b1;
            end
        end
    end

    assign tx_ready = armed && !busy;
    assign txd      = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/uart_xcvr_rx.sv
module uart_xcvr_rx
    import uart_xcvr_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  line_cfg_t cfg,
    input  logic      tick,
    input  logic      rxd,
    output logic      done,
    output rx_word_t  word
);
    localparam int unsigned TW = $clog2(OSR);
    localparam logic [TW-1:0] T_LAST = TW'(OSR - 1);
    localparam logic [TW-1:0] T_MID  = TW'(OSR / 2 - 1);

    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_e;

    rx_state_e        state;
    logic [TW-1:0]    tcnt;
    logic [CNT_W-1:0] idx;
    data_t            raw;
    logic             pbit;
    logic             ferr;
    logic             stop_left;
    logic             line_prev;
    logic             bit_end;
    data_t            fin_data;

    assign bit_end  = tick && (tcnt == T_LAST);
    assign fin_data = mask_data(reorder(raw, cfg), cfg.nbits);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state     <= RX_IDLE;
            tcnt      <= '0;
            idx       <= '0;
            raw       <= '0;
            pbit      <= 1'b0;
            ferr      <= 1'b0;
            stop_left <= 1'b0;
            line_prev <= rst ? 1'b1 : rxd;
            done      <= 1'b0;
            word      <= '0;
        end else begin
            done      <= 1'b0;
            line_prev <= rxd;
            if (tick && state != RX_IDLE)
                tcnt <= bit_end ? '0 : tcnt + 1'b1;
            unique case (state)
                RX_IDLE: begin
                    if (line_prev && !rxd) begin
                        state <= RX_START;
                        tcnt  <= '0;
                    end
                end
                RX_START: begin
                    if (tick && tcnt == T_MID) begin
                        tcnt <= '0;
                        idx  <= '0;
                        ferr <= 1'b0;
                        state <= rxd ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (bit_end) begin
                        raw[idx] <= rxd ^ cfg.invert;
                        if (idx == cfg.nbits - 1'b1) begin
                            state     <= cfg.par_en ? RX_PAR : RX_STOP;
                            stop_left <= cfg.two_stop;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                RX_PAR: begin
                    if (bit_end) begin
                        pbit  <= rxd;
                        state <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (bit_end) begin
                        ferr <= ferr | !rxd;
                        if (stop_left) begin
                            stop_left <= 1'b0;
                        end else begin
                            state          <= RX_IDLE;
                            done           <= 1'b1;
                            word.data      <= fin_data;
                            word.frame_err <= ferr | !rxd;
                            word.par_err   <= cfg.par_en && (parity_of(fin_data, cfg) != pbit);
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_xcvr_rxbuf.sv
module uart_xcvr_rxbuf
    import uart_xcvr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     done,
    input  rx_word_t word,
    input  logic     read,
    output data_t    data,
    output logic     valid,
    output logic     frame_err,
    output logic     par_err,
    output logic     overrun
);
    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            data      <= '0;
            valid     <= 1'b0;
            frame_err <= 1'b0;
            par_err   <= 1'b0;
            overrun   <= 1'b0;
        end else if (done) begin
            if (valid && !read) begin
                overrun <= 1'b1;
            end else begin
                data      <= word.data;
                frame_err <= word.frame_err;
                par_err   <= word.par_err;
                valid     <= 1'b1;
                overrun   <= 1'b0;
            end
        end else if (read) begin
            valid     <= 1'b0;
            frame_err <= 1'b0;
            par_err   <= 1'b0;
            overrun   <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
    import uart_xcvr_pkg::*;
#(
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                baud_tick,
    input  logic [2:0]          mode,
    input  logic                msb_first,
    input  logic                invert,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                two_stop,
    input  logic                tx_arm,
    input  logic                rx_en,
    input  logic [DATA_MAX-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic                txd,
    input  logic                rxd,
    input  logic                rx_read,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_frame_err,
    output logic                rx_par_err,
    output logic                rx_overrun
);
    line_cfg_t cfg;
    logic      uart_on;
    logic      rx_on;
    logic      rxd_s;
    logic      rx_done;
    rx_word_t  rx_word;

    always_comb begin
        cfg.nbits     = mode_bits(mode);
        cfg.msb_first = msb_first;
        cfg.invert    = invert;
        cfg.par_en    = par_en;
        cfg.par_odd   = par_odd;
        cfg.two_stop  = two_stop;
    end

    assign uart_on = mode_is_uart(mode);
    assign rx_on   = uart_on && rx_en;

    uart_xcvr_tx #(.OSR(OSR)) u_tx (
        .clk(clk), .rst(rst), .enable(uart_on), .cfg(cfg), .tick(baud_tick),
        .arm(tx_arm), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .txd(txd)
    );

    uart_xcvr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(rxd_s)
    );

    uart_xcvr_rx #(.OSR(OSR)) u_rx (
        .clk(clk), .rst(rst), .enable(rx_on), .cfg(cfg), .tick(baud_tick),
        .rxd(rxd_s), .done(rx_done), .word(rx_word)
    );

    uart_xcvr_rxbuf u_buf (
        .clk(clk), .rst(rst), .enable(rx_on), .done(rx_done), .word(rx_word),
        .read(rx_read), .data(rx_data), .valid(rx_valid),
        .frame_err(rx_frame_err), .par_err(rx_par_err), .overrun(rx_overrun)
    );
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
    input logic       clk,
    input logic       rst,
    input logic       baud_tick,
    input logic [2:0] mode,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       txd,
    input logic       rx_en,
    input logic       rx_read,
    input logic       rx_valid,
    input logic       rx_frame_err,
    input logic       rx_par_err,
    input logic       rx_overrun
);
    logic mode_ok;
    assign mode_ok = (mode == 3'b100) || (mode == 3'b101) || (mode == 3'b110);

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> txd);

    assert_hold_between_ticks_R1: assert property (@(posedge clk) disable iff (rst)
        (!baud_tick && mode_ok && !(tx_valid && tx_ready)) |=> $stable(txd));

    assert_start_after_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && mode_ok) |=> (!txd && !tx_ready));

    assert_mode_off_R7: assert property (@(posedge clk) disable iff (rst)
        !mode_ok |=> (txd && !tx_ready && !rx_valid));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_read && rx_valid && rx_en && mode_ok) |=> (!rx_overrun));

    assert_overrun_needs_held_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_valid));

    assert_rx_disable_clears_R13: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!rx_valid && !rx_overrun && !rx_frame_err && !rx_par_err));
endmodule

bind uart_xcvr uart_xcvr_chk u_chk (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .mode(mode),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .rx_en(rx_en), .rx_read(rx_read), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err), .rx_overrun(rx_overrun)
);

// File: tb/uart_xcvr_test.sv
`timescale 1ns/1ps
module uart_xcvr_test;
    localparam int TP  = 3;
    localparam int OSR = 16;
    localparam int BIT = OSR * TP;

    typedef bit bitq_t[$];

    logic       clk = 1'b0;
    logic       rst;
    logic       baud_tick;
    logic [2:0] mode;
    logic       msb_first, invert, par_en, par_odd, two_stop;
    logic       tx_arm, rx_en, tx_valid, rx_read;
    logic [8:0] tx_data;
    logic       tx_ready, txd, rxd;
    logic [8:0] rx_data;
    logic       rx_valid, rx_frame_err, rx_par_err, rx_overrun;
    logic       loop, drv_rxd;

    int  tests = 0;
    int  fails = 0;
    bit  finished = 0;

    always #2 clk = ~clk;
    assign rxd = loop ? txd : drv_rxd;

    uart_xcvr uut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .mode(mode),
        .msb_first(msb_first), .invert(invert), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .tx_arm(tx_arm), .rx_en(rx_en), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
        .rx_read(rx_read), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err), .rx_overrun(rx_overrun)
    );

    function automatic int len_of(input logic [2:0] m);
        if (m == 3'b100) return 7;
        if (m == 3'b101) return 8;
        if (m == 3'b110) return 9;
        return 0;
    endfunction

    function automatic bitq_t frame_bits(input logic [8:0] d, input int n, input bit msb,
                                         input bit inv, input bit pen, input bit podd, input bit two);
        bitq_t q;
        bit p;
        p = podd;
        q.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            int k;
            k = (msb && n == 8) ? 7 - i : i;
            q.push_back(d[k] ^ inv);
        end
        for (int i = 0; i < n; i++) p = p ^ d[i];
        if (pen) q.push_back(p);
        q.push_back(1'b1);
        if (two) q.push_back(1'b1);
        return q;
    endfunction

    // tick generator
    int tdiv = 0;
    always @(negedge clk) begin
        if (rst) begin
            tdiv = 0;
            baud_tick = 1'b0;
        end else begin
            baud_tick = (tdiv == TP - 1);
            tdiv = (tdiv + 1) % TP;
        end
    end

    // behavioural transmit model, advanced on every clock from the inputs only
    bit    m_busy = 0, m_armed = 0;
    int    m_ticks = 0;
    bitq_t m_frame;
    always @(posedge clk) begin
        if (rst || len_of(mode) == 0) begin
            m_busy  = 0;
            m_armed = 0;
        end else begin
            if (m_busy) begin
                if (baud_tick) begin
                    m_ticks++;
                    if (m_ticks == OSR * m_frame.size()) m_busy = 0;
                end
            end else if (m_armed && tx_valid) begin
                m_frame = frame_bits(tx_data, len_of(mode), msb_first, invert, par_en, par_odd, two_stop);
                m_ticks = 0;
                m_busy  = 1;
            end
            if (tx_arm) m_armed = 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic exp_txd;
            exp_txd = m_busy ? m_frame[m_ticks / OSR] : 1'b1;
            tests++;
            if (txd !== exp_txd) begin
                fails++;
                $display("FAIL R1/R2/R3/R4/R5 txd actual=%0b expected=%0b at %0t", txd, exp_txd, $time);
            end
            tests++;
            if (tx_ready !== (m_armed && !m_busy)) begin
                fails++;
                $display("FAIL R6/R7 tx_ready actual=%0b expected=%0b at %0t", tx_ready, m_armed && !m_busy, $time);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [2:0] m, input bit msb, input bit inv,
                           input bit pen, input bit podd, input bit two);
        @(negedge clk);
        mode = m; msb_first = msb; invert = inv; par_en = pen; par_odd = podd; two_stop = two;
        cyc(2);
    endtask

    task automatic arm();
        @(negedge clk); tx_arm = 1'b1;
        @(negedge clk); tx_arm = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); rx_read = 1'b1;
        @(negedge clk); rx_read = 1'b0;
    endtask

    task automatic offer(input logic [8:0] d);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = d; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic send_loop(input logic [8:0] d, input string tag);
        logic [8:0] msk;
        msk = 9'((1 << len_of(mode)) - 1);
        loop = 1'b1;
        offer(d);
        while (!tx_ready) @(negedge clk);
        cyc(4);
        chk({tag, " loopback rx_valid"}, rx_valid, 1);
        chk({tag, " loopback rx_data"}, rx_data, d & msk);
        chk({tag, " loopback no errors"}, {rx_frame_err, rx_par_err, rx_overrun}, 0);
        rd();
        loop = 1'b0;
    endtask

    task automatic drive(input bitq_t q);
        foreach (q[i]) begin
            drv_rxd = q[i];
            cyc(BIT);
        end
        drv_rxd = 1'b1;
        cyc(6);
    endtask

    initial begin
        bitq_t q;
        rst = 1; mode = 3'b000; msb_first = 0; invert = 0; par_en = 0; par_odd = 0; two_stop = 0;
        tx_arm = 0; rx_en = 0; tx_valid = 0; rx_read = 0; tx_data = 0; loop = 0; drv_rxd = 1;
        cyc(5);
        rst = 0;
        cyc(2);
        chk("R1 reset txd high", txd, 1);
        chk("R6 reset tx_ready low", tx_ready, 0);
        chk("R9 reset rx_valid low", rx_valid, 0);

        set_cfg(3'b101, 0, 0, 0, 0, 0);
        rx_en = 1;
        chk("R7 not armed before tx_arm", tx_ready, 0);
        arm();
        chk("R6 armed and idle gives tx_ready", tx_ready, 1);

        // loopback frames under several formats (line checked every clock)
        send_loop(9'h0A5, "R1 8-bit lsb");
        set_cfg(3'b101, 1, 0, 1, 0, 0);
        send_loop(9'h001, "R2 msb first even parity");
        set_cfg(3'b101, 1, 1, 1, 1, 1);
        send_loop(9'h03C, "R3 inverted odd parity two stop");
        set_cfg(3'b100, 1, 0, 1, 0, 0);
        send_loop(9'h0D5, "R2 7-bit ignores msb_first");
        set_cfg(3'b110, 0, 1, 1, 1, 1);
        send_loop(9'h1A7, "R4 9-bit odd parity");
        set_cfg(3'b100, 0, 0, 0, 0, 1);
        send_loop(9'h07F, "R5 7-bit two stop");

        // R7: abort through mode, then re-arm
        set_cfg(3'b101, 0, 0, 0, 0, 0);
        offer(9'h0F0);
        cyc(100);
        mode = 3'b000;
        cyc(1);
        chk("R7 mode off forces txd high", txd, 1);
        chk("R7 mode off drops tx_ready", tx_ready, 0);
        mode = 3'b101;
        cyc(3);
        chk("R7 stays disarmed after mode restored", tx_ready, 0);
        arm();
        chk("R7 tx_arm re-arms", tx_ready, 1);
        arm();
        chk("R7 tx_arm while armed keeps armed", tx_ready, 1);
        send_loop(9'h0C3, "R7 after re-arm");

        // direct receive: basic delivery and overrun
        set_cfg(3'b101, 0, 0, 0, 0, 0);
        drive(frame_bits(9'h096, 8, 0, 0, 0, 0, 0));
        chk("R9 rx_valid after frame", rx_valid, 1);
        chk("R9 rx_data", rx_data, 9'h096);
        chk("R9 clean frame flags", {rx_frame_err, rx_par_err, rx_overrun}, 0);
        drive(frame_bits(9'h011, 8, 0, 0, 0, 0, 0));
        chk("R12 overrun set", rx_overrun, 1);
        chk("R12 held byte kept", rx_data, 9'h096);
        rd();
        chk("R9 read clears rx_valid", rx_valid, 0);
        chk("R12 read clears overrun", rx_overrun, 0);

        // R11 parity mismatch (7-bit even expected, odd sent)
        set_cfg(3'b100, 0, 0, 1, 0, 0);
        drive(frame_bits(9'h02B, 7, 0, 0, 1, 1, 0));
        chk("R11 parity error flag", rx_par_err, 1);
        chk("R11 data still delivered", rx_data, 9'h02B);
        chk("R11 no framing error", rx_frame_err, 0);
        rd();

        // R10 low stop bit in 9-bit mode
        set_cfg(3'b110, 0, 0, 0, 0, 0);
        q = frame_bits(9'h155, 9, 0, 0, 0, 0, 0);
        q[q.size()-1] = 1'b0;
        drive(q);
        chk("R10 framing error on low stop", rx_frame_err, 1);
        chk("R10 data with 9 bits", rx_data, 9'h155);
        rd();

        // R5 second stop bit low
        set_cfg(3'b101, 0, 0, 0, 0, 1);
        q = frame_bits(9'h0E1, 8, 0, 0, 0, 0, 1);
        q[q.size()-1] = 1'b0;
        drive(q);
        chk("R5 second stop checked", rx_frame_err, 1);
        rd();

        // R8 glitch rejection
        set_cfg(3'b101, 0, 0, 0, 0, 0);
        drv_rxd = 1'b0;
        cyc(4 * TP);
        drv_rxd = 1'b1;
        cyc(2 * BIT);
        chk("R8 short low pulse ignored", rx_valid, 0);
        drive(frame_bits(9'h05A, 8, 0, 0, 0, 0, 0));
        chk("R8 frame after glitch", rx_data, 9'h05A);
        chk("R8 frame after glitch valid", rx_valid, 1);
        rd();

        // R2 receive msb first with inversion
        set_cfg(3'b101, 1, 1, 0, 0, 0);
        drive(frame_bits(9'h0B2, 8, 1, 1, 0, 0, 0));
        chk("R2 msb first inverted receive", rx_data, 9'h0B2);
        rd();

        // R13 receive-enable toggle
        set_cfg(3'b101, 0, 0, 0, 0, 0);
        drive(frame_bits(9'h001, 8, 0, 0, 0, 0, 0));
        drive(frame_bits(9'h002, 8, 0, 0, 0, 0, 0));
        chk("R13 setup overrun", rx_overrun, 1);
        drv_rxd = 1'b0;
        cyc(BIT);
        drv_rxd = 1'b1;
        cyc(3 * BIT);
        rx_en = 1'b0;
        cyc(1);
        chk("R13 disable clears rx_valid", rx_valid, 0);
        chk("R13 disable clears overrun", rx_overrun, 0);
        rx_en = 1'b1;
        cyc(7 * BIT);
        chk("R13 partial frame dropped", rx_valid, 0);
        drive(frame_bits(9'h042, 8, 0, 0, 0, 0, 0));
        chk("R13 receive after re-enable", rx_data, 9'h042);
        chk("R13 receive after re-enable valid", rx_valid, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL R1 watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule